// File: doc/BRIEF.md
# Compare and Branch Unit

This unit executes a signed compare and a family of program-counter-relative branches for a small 32-bit core. The compare reads a register value and either a second register value or an immediate. It records the outcome in three status flags that are mutually exclusive: less, equal and greater. Each conditional branch tests exactly one of these flags. The unconditional branch and branch-with-link are always taken.

The unit receives an already decoded operation, the operands, a signed byte offset and the program counter. That program counter has already been advanced by 4 past the current instruction. Branch results (taken, next PC, link strobe and link value) are combinational from the current inputs and the stored flags. The flags are registered. A compare updates them at the clock edge that ends its cycle, so a branch in the following cycle sees the new outcome. The status word can also be overwritten as a whole. Each operation occupies one cycle.

Top module: `cbu_core`

## Requirements
- R1: After a synchronous active-low reset, all three flags are 0 and `stat_o` is 0.
- R2: A compare (op 1) compares the operands as signed 32-bit integers. From the next clock edge exactly one flag is 1: less when the first operand is smaller, equal when the operands match, greater otherwise.
- R3: When `imm_sel_i` is 1, the compare uses `opb_imm_i` as its second operand; when it is 0, it uses `opb_reg_i`.
- R4: The branch target is `pc_i - 4 + offset_i`, with the offset in two's complement and the sum wrapping modulo 2^32.
- R5: The conditional branches are taken on these flags: op 3 when equal=1, op 4 when equal=0, op 5 when greater=1, op 6 when less=1.
- R6: The unconditional branch (op 2) and branch-with-link (op 7) are always taken. A taken branch drives the target on `next_pc_o` and sets `branch_taken_o`.
- R7: When no branch is taken, including on op 0 (no operation) and op 1, `next_pc_o` equals `pc_i` and `branch_taken_o` is 0.
- R8: Branch-with-link (op 7) raises `link_we_o` with `link_val_o = pc_i`. All other ops hold `link_we_o` at 0.
- R9: `stat_we_i` loads the flags from `stat_wdata_i`: bit 31 is less, bit 30 is equal and bit 29 is greater. It takes priority over a compare in the same cycle. `stat_o` carries the flags at those bit positions and 0 elsewhere.
- R10: Ops other than compare, without a status write, leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Decoded operation: 0 none, 1 compare, 2 branch, 3 if equal, 4 if not equal, 5 if greater, 6 if less, 7 with link |
| opa_i | input | 32 | First compare operand |
| opb_reg_i | input | 32 | Second operand, register form |
| opb_imm_i | input | 32 | Second operand, immediate form |
| imm_sel_i | input | 1 | Selects the immediate as the second operand |
| offset_i | input | 32 | Signed branch byte offset |
| pc_i | input | 32 | Program counter, already advanced by 4 |
| stat_we_i | input | 1 | Status word write strobe |
| stat_wdata_i | input | 32 | Status word write data |
| stat_o | output | 32 | Status word: flags in bits 31..29 |
| flag_lt_o | output | 1 | Less flag |
| flag_eq_o | output | 1 | Equal flag |
| flag_gt_o | output | 1 | Greater flag |
| next_pc_o | output | 32 | Next program counter |
| branch_taken_o | output | 1 | Branch taken this cycle |
| link_we_o | output | 1 | Link register write strobe |
| link_val_o | output | 32 | Value to write to the link register |

## Verification
A wrong flag state appears at the status port one clock after the compare or write that caused it. It then shows as a wrong taken decision on the next conditional branch in that same cycle. Errors in the target adder or the link path show up in the same cycle as the branch, on `next_pc_o` and `link_val_o`. For that reason the reference model compares every output on every cycle. Sign boundaries (0x80000000 against 0x7FFFFFFF) and wrapping offsets are driven on purpose.

// File: rtl/cbu_pkg.sv
// Shared types for the compare and branch unit.
// Assumes a 3-bit decoded operation field supplied by an external decoder.
package cbu_pkg;
    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_CMP = 3'd1,
        OP_B   = 3'd2,
        OP_BEQ = 3'd3,
        OP_BNE = 3'd4,
        OP_BGT = 3'd5,
        OP_BLT = 3'd6,
        OP_BL  = 3'd7
    } cbu_op_e;

    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
    } cbu_flags_t;
endpackage

// File: rtl/cbu_compare.sv
// Signed magnitude comparator producing one-hot less/equal/greater flags.
// Assumes both operands are two's complement values of DATA_W bits.
module cbu_compare
    import cbu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output cbu_flags_t        res_o
);
    // Classify the operand pair into exactly one outcome.
    always_comb begin
        res_o = '0;
        if ($signed(a_i) < $signed(b_i)) begin
            res_o.lt = 1'b1;
        end else if (a_i == b_i) begin
            res_o.eq = 1'b1;
        end else begin
            res_o.gt = 1'b1;
        end
    end
endmodule

// File: rtl/cbu_flagreg.sv
// Status flag register. It loads on a compare or on a whole-word write;
// the write wins when both happen in one cycle.
// Assumes the flags sit at the top three bits of the status word.
module cbu_flagreg
    import cbu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_en_i,
    input  cbu_flags_t        cmp_res_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output cbu_flags_t        flags_o,
    output logic [DATA_W-1:0] stat_o
);
    localparam int LT_POS = DATA_W - 1;
    localparam int EQ_POS = DATA_W - 2;
    localparam int GT_POS = DATA_W - 3;

    cbu_flags_t flags_q;

    // Hold the flags; reset clears, a write has priority over a compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (wr_en_i) begin
            flags_q <= {wr_data_i[LT_POS], wr_data_i[EQ_POS], wr_data_i[GT_POS]};
        end else if (cmp_en_i) begin
            flags_q <= cmp_res_i;
        end
    end

    // Place the flags into the status word layout.
    always_comb begin
        stat_o         = '0;
        stat_o[LT_POS] = flags_q.lt;
        stat_o[EQ_POS] = flags_q.eq;
        stat_o[GT_POS] = flags_q.gt;
    end

    assign flags_o = flags_q;

    assert_cmp_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en_i && !wr_en_i) |=> ($countones(flags_q) == 1));

    assert_write_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (stat_o[LT_POS:GT_POS] == $past(wr_data_i[LT_POS:GT_POS])));

    assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_en_i && !wr_en_i) |=> $stable(flags_q));
endmodule

// File: rtl/cbu_branch.sv
// Branch resolution: computes the PC-relative target, the taken decision
// from the stored flags, and the link strobe and value.
// Assumes pc_i already points one instruction past the branch.
module cbu_branch
    import cbu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  cbu_op_e           op_i,
    input  cbu_flags_t        flags_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] offset_i,
    output logic              taken_o,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic              link_we_o,
    output logic [ADDR_W-1:0] link_val_o
);
    localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

    logic [ADDR_W-1:0] target;

    // Target relative to the branch's own address, wrapping.
    assign target = pc_i - INSN_BYTES + offset_i;

    // Decide whether the current op redirects the PC.
    always_comb begin
        unique case (op_i)
            OP_B, OP_BL: taken_o = 1'b1;
            OP_BEQ:      taken_o = flags_i.eq;
            OP_BNE:      taken_o = !flags_i.eq;
            OP_BGT:      taken_o = flags_i.gt;
            OP_BLT:      taken_o = flags_i.lt;
            default:     taken_o = 1'b0;
        endcase
    end

    // Select the next PC and the link outputs.
    always_comb begin
        next_pc_o  = taken_o ? target : pc_i;
        link_we_o  = (op_i == OP_BL);
        link_val_o = pc_i;
    end

    always_comb begin
        assert_not_taken_R7: assert (taken_o || (next_pc_o == pc_i));
        assert_link_taken_R8: assert (!link_we_o || (taken_o && link_val_o == pc_i));
        assert_uncond_R6: assert (!(op_i == OP_B || op_i == OP_BL) || taken_o);
    end
endmodule

// File: rtl/cbu_core.sv
// Top of the compare and branch unit. Selects the second compare operand,
// feeds the comparator into the flag register and resolves branches
// against the stored flags. One operation per cycle.
module cbu_core
    import cbu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_reg_i,
    input  logic [DATA_W-1:0] opb_imm_i,
    input  logic              imm_sel_i,
    input  logic [DATA_W-1:0] offset_i,
    input  logic [DATA_W-1:0] pc_i,
    input  logic              stat_we_i,
    input  logic [DATA_W-1:0] stat_wdata_i,
    output logic [DATA_W-1:0] stat_o,
    output logic              flag_lt_o,
    output logic              flag_eq_o,
    output logic              flag_gt_o,
    output logic [DATA_W-1:0] next_pc_o,
    output logic              branch_taken_o,
    output logic              link_we_o,
    output logic [DATA_W-1:0] link_val_o
);
    cbu_op_e           op;
    logic [DATA_W-1:0] opb;
    cbu_flags_t        cmp_res;
    cbu_flags_t        flags;

    // Decode the op field and pick the second operand.
    always_comb begin
        op  = cbu_op_e'(op_i);
        opb = imm_sel_i ? opb_imm_i : opb_reg_i;
    end

    cbu_compare #(.DATA_W(DATA_W)) u_cmp (
        .a_i   (opa_i),
        .b_i   (opb),
        .res_o (cmp_res)
    );

    cbu_flagreg #(.DATA_W(DATA_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_en_i  (op == OP_CMP),
        .cmp_res_i (cmp_res),
        .wr_en_i   (stat_we_i),
        .wr_data_i (stat_wdata_i),
        .flags_o   (flags),
        .stat_o    (stat_o)
    );

    cbu_branch #(.ADDR_W(DATA_W)) u_br (
        .op_i       (op),
        .flags_i    (flags),
        .pc_i       (pc_i),
        .offset_i   (offset_i),
        .taken_o    (branch_taken_o),
        .next_pc_o  (next_pc_o),
        .link_we_o  (link_we_o),
        .link_val_o (link_val_o)
    );

    assign flag_lt_o = flags.lt;
    assign flag_eq_o = flags.eq;
    assign flag_gt_o = flags.gt;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (stat_o == '0));
endmodule

// File: tb/cbu_core_tb_top.sv
module cbu_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  op;
    logic [31:0] opa, opb_reg, opb_imm, offset, pc, wdata;
    logic        imm_sel, we;
    logic [31:0] stat, next_pc, link_val;
    logic        lt, eq, gt, taken, link_we;

    int vectors = 0;
    int fails = 0;
    logic m_lt = 0, m_eq = 0, m_gt = 0;

    always #5 clk = ~clk;

    cbu_core dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op), .opa_i(opa), .opb_reg_i(opb_reg),
        .opb_imm_i(opb_imm), .imm_sel_i(imm_sel), .offset_i(offset), .pc_i(pc),
        .stat_we_i(we), .stat_wdata_i(wdata), .stat_o(stat), .flag_lt_o(lt),
        .flag_eq_o(eq), .flag_gt_o(gt), .next_pc_o(next_pc),
        .branch_taken_o(taken), .link_we_o(link_we), .link_val_o(link_val)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one op at the falling edge, compare all outputs, then advance the model.
    task automatic step(input logic [2:0] o, input logic [31:0] a, input logic [31:0] br,
                        input logic [31:0] bi, input logic sel, input logic [31:0] off,
                        input logic [31:0] p, input logic w, input logic [31:0] wd);
        logic        e_taken;
        logic [31:0] b, e_stat;
        @(negedge clk);
        op = o; opa = a; opb_reg = br; opb_imm = bi; imm_sel = sel;
        offset = off; pc = p; we = w; wdata = wd;
        #1;
        case (o)
            3'd2, 3'd7: e_taken = 1'b1;
            3'd3: e_taken = m_eq;
            3'd4: e_taken = !m_eq;
            3'd5: e_taken = m_gt;
            3'd6: e_taken = m_lt;
            default: e_taken = 1'b0;
        endcase
        e_stat = {m_lt, m_eq, m_gt, 29'd0};
        chk("R2/R9 stat_o", stat, e_stat);
        chk("R5/R6/R7 taken", {31'd0, taken}, {31'd0, e_taken});
        if (e_taken) chk("R4 target", next_pc, p - 32'd4 + off);
        else         chk("R7 next_pc", next_pc, p);
        chk("R8 link_we", {31'd0, link_we}, {31'd0, (o == 3'd7)});
        if (o == 3'd7) chk("R8 link_val", link_val, p);
        b = sel ? bi : br;
        if (w) begin
            m_lt = wd[31]; m_eq = wd[30]; m_gt = wd[29];
        end else if (o == 3'd1) begin
            m_lt = $signed(a) < $signed(b);
            m_eq = (a == b);
            m_gt = !m_lt && !m_eq;
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op = 0; opa = 0; opb_reg = 0; opb_imm = 0; imm_sel = 0;
        offset = 0; pc = 0; we = 0; wdata = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset stat_o", stat, 32'd0);
        chk("R1 reset flags", {29'd0, lt, eq, gt}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R2 signed boundaries and equality; R3 operand select.
        step(3'd1, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, 0, 32'h100, 0, 0);
        step(3'd6, 0, 0, 0, 0, 32'h20, 32'h104, 0, 0);       // R5 less taken
        step(3'd1, 32'h7FFF_FFFF, 32'h8000_0000, 0, 0, 0, 32'h108, 0, 0);
        step(3'd5, 0, 0, 0, 0, 32'hFFFF_FFF0, 32'h10C, 0, 0); // R5 greater, negative offset
        step(3'd1, 32'd5, 32'd9, 32'd5, 1, 0, 32'h110, 0, 0);   // R3 immediate
        step(3'd3, 0, 0, 0, 0, 32'h8, 32'h114, 0, 0);          // R5 equal taken
        step(3'd4, 0, 0, 0, 0, 32'h8, 32'h118, 0, 0);          // R5 not-equal not taken
        step(3'd0, 0, 0, 0, 0, 32'h8, 32'h11C, 0, 0);          // R7 nop, R10 hold
        step(3'd7, 0, 0, 0, 0, 32'h8000_0000, 32'h8000_0004, 0, 0); // R4 wrap, R8 link
        step(3'd2, 0, 0, 0, 0, 32'h0, 32'h0000_0002, 0, 0);    // R4 wrap below zero
        // R9 write sets multiple flags, then wins over a simultaneous compare.
        step(3'd0, 0, 0, 0, 0, 0, 32'h200, 1, 32'hE000_0000);
        step(3'd1, 32'd1, 32'd1, 0, 0, 0, 32'h204, 1, 32'h2000_FFFF);
        step(3'd5, 0, 0, 0, 0, 32'h40, 32'h208, 0, 0);
        step(3'd3, 0, 0, 0, 0, 32'h40, 32'h20C, 0, 0);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a = $urandom;
            logic [31:0] r = ($urandom_range(0, 3) == 0) ? a : $urandom;
            step(3'($urandom_range(0, 7)), a, r, ($urandom_range(0, 3) == 0) ? a : $urandom,
                 1'($urandom), $urandom, $urandom, ($urandom_range(0, 15) == 0), $urandom);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule